// File: doc/BRIEF.md
# Snoop Address Hold and Invalidation Port

This block sits on a processor's external bus and lets another bus master invalidate lines in the on-chip cache. While the address-hold input is high, the block stops driving the processor's address lines. The data lines and the rest of the bus keep running as usual, so a transfer the core has started is not stalled by the hold.

During address hold the external master drives an address onto the address pins and pulls the active-low external-address strobe. On every clock edge where the strobe is sampled low and hold is high, the block captures the address and aligns it to a cache line by clearing the line-offset bits. In the next clock it sends exactly one invalidation request to the cache tag array. The request is a one-cycle valid pulse carrying that address.

A strobe that arrives while hold is low does not invalidate anything. It is counted in a saturating error counter instead.

Top module: `snp_ahold_port`

## Requirements
- R1: After reset, `addr_oe` is 1, `data_oe` is 0, `inv_valid` is 0 and `err_cnt` is 0.
- R2: `addr_oe` is 0 in the clock after a rising edge at which `ahold` is sampled 1.
- R3: `addr_oe` is 1 in the clock after a rising edge at which `ahold` is sampled 0.
- R4: In the clock after every edge, `data_oe`, `data_out` and `addr_out` equal the values that edge sampled on `core_data_en`, `core_data` and `core_addr`. This holds whatever the value of `ahold`.
- R5: An edge that samples `ext_stb_n` = 0 and `ahold` = 1 is a snoop strobe. It makes `inv_valid` 1 for the following clock. During that clock `inv_addr` equals the sampled `ext_addr` with bits [LINE_BITS-1:0] forced to 0 (LINE_BITS = 4 by default).
- R6: Snoop strobes on consecutive edges give one pulse each, on consecutive clocks, in strobe order.
- R7: `inv_valid` is 0 in the clock after any edge that is not a snoop strobe.
- R8: An edge that samples `ext_stb_n` = 0 with `ahold` = 0 is a stray strobe. It produces no invalidation and increases `err_cnt` by one in the next clock.
- R9: `err_cnt` saturates at 2^CW-1 (15 by default) and stays there on further stray strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahold | input | 1 | Address-hold request, active high |
| ext_stb_n | input | 1 | External-address strobe, active low |
| ext_addr | input | AW | Address driven by the external master |
| core_addr | input | AW | Address the core wants to drive |
| core_data | input | DW | Data the core wants to drive |
| core_data_en | input | 1 | Core requests the data lines be driven |
| addr_out | output | AW | Registered address to the pins |
| addr_oe | output | 1 | Address line output enable |
| data_out | output | DW | Registered data to the pins |
| data_oe | output | 1 | Data line output enable |
| inv_valid | output | 1 | One-cycle invalidation request to the tag array |
| inv_addr | output | AW | Line-aligned address of the invalidation |
| err_cnt | output | CW | Saturating count of stray strobes |

## Verification
Single snoop strobes are driven with addresses that are zero, all ones and with set offset bits. These show whether the line-offset bits are cleared and the upper bits kept. A burst of strobes on consecutive edges separates one pulse per edge from pulses that are merged or dropped, and checks that the order is kept. Strobes with hold low, repeated past the counter limit, tell stray strobes apart from real snoops and show the saturation. Toggling the core's data enable while hold is high confirms that only the address enable reacts to the hold.

// File: rtl/snp_pkg.sv
package snp_pkg;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_SNOOP = 2'd1,
      EV_STRAY = 2'd2
   } snp_event_e;

   function automatic snp_event_e classify(input logic hold, input logic stb_n);
      if (stb_n)
         return EV_NONE;
      else if (hold)
         return EV_SNOOP;
      else
         return EV_STRAY;
   endfunction

endpackage

// File: rtl/snp_bus_drive.sv
module snp_bus_drive #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ahold,
   input  logic [AW-1:0] core_addr,
   input  logic [DW-1:0] core_data,
   input  logic          core_data_en,
   output logic [AW-1:0] addr_out,
   output logic          addr_oe,
   output logic [DW-1:0] data_out,
   output logic          data_oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_oe  <= 1'b1;
         addr_out <= '0;
      end else begin
         addr_oe  <= ~ahold;
         addr_out <= core_addr;
      end
   end

   // the data side never looks at the hold request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_oe  <= 1'b0;
         data_out <= '0;
      end else begin
         data_oe  <= core_data_en;
         data_out <= core_data;
      end
   end

endmodule

// File: rtl/snp_inv_capture.sv
module snp_inv_capture
   import snp_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LINE_BITS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  snp_event_e    ev,
   input  logic [AW-1:0] ext_addr,
   output logic          inv_valid,
   output logic [AW-1:0] inv_addr
);

   logic [AW-1:0] line_addr;

   generate
      if (LINE_BITS > 0) begin : g_align
         assign line_addr = {ext_addr[AW-1:LINE_BITS], {LINE_BITS{1'b0}}};
      end else begin : g_pass
         assign line_addr = ext_addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_valid <= 1'b0;
         inv_addr  <= '0;
      end else begin
         inv_valid <= (ev == EV_SNOOP);
         if (ev == EV_SNOOP)
            inv_addr <= line_addr;
      end
   end

endmodule

// File: rtl/snp_err_count.sv
module snp_err_count #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bump,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (bump && count != TOP)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/snp_ahold_port.sv
module snp_ahold_port
   import snp_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LINE_BITS = 4,
   parameter int CW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ahold,
   input  logic          ext_stb_n,
   input  logic [AW-1:0] ext_addr,
   input  logic [AW-1:0] core_addr,
   input  logic [DW-1:0] core_data,
   input  logic          core_data_en,
   output logic [AW-1:0] addr_out,
   output logic          addr_oe,
   output logic [DW-1:0] data_out,
   output logic          data_oe,
   output logic          inv_valid,
   output logic [AW-1:0] inv_addr,
   output logic [CW-1:0] err_cnt
);

   generate
      if (AW < 1 || DW < 1 || CW < 1) begin : g_bad_width
         $error("snp_ahold_port: widths must be positive");
      end
      if (LINE_BITS < 0 || LINE_BITS >= AW) begin : g_bad_line
         $error("snp_ahold_port: LINE_BITS must be below AW");
      end
   endgenerate

   snp_event_e ev;
   assign ev = classify(ahold, ext_stb_n);

   snp_bus_drive #(.AW(AW), .DW(DW)) u_drive (
      .clk          (clk),
      .rst_n        (rst_n),
      .ahold        (ahold),
      .core_addr    (core_addr),
      .core_data    (core_data),
      .core_data_en (core_data_en),
      .addr_out     (addr_out),
      .addr_oe      (addr_oe),
      .data_out     (data_out),
      .data_oe      (data_oe)
   );

   snp_inv_capture #(.AW(AW), .LINE_BITS(LINE_BITS)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .ext_addr  (ext_addr),
      .inv_valid (inv_valid),
      .inv_addr  (inv_addr)
   );

   snp_err_count #(.CW(CW)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (ev == EV_STRAY),
      .count (err_cnt)
   );

endmodule

// File: rtl/snp_ahold_port_chk.sv
module snp_ahold_port_chk #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int LINE_BITS = 4,
   parameter int CW        = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ahold,
   input logic          ext_stb_n,
   input logic [AW-1:0] ext_addr,
   input logic [AW-1:0] core_addr,
   input logic [DW-1:0] core_data,
   input logic          core_data_en,
   input logic [AW-1:0] addr_out,
   input logic          addr_oe,
   input logic [DW-1:0] data_out,
   input logic          data_oe,
   input logic          inv_valid,
   input logic [AW-1:0] inv_addr,
   input logic [CW-1:0] err_cnt
);

   localparam logic [AW-1:0] OFS_MASK = AW'((64'd1 << LINE_BITS) - 64'd1);
   localparam logic [CW-1:0] CNT_TOP  = '1;

   a_r2_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ahold |=> !addr_oe);

   a_r3_oe_back: assert property (@(posedge clk) disable iff (!rst_n)
      !ahold |=> addr_oe);

   a_r4_bus_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (data_oe == $past(core_data_en)) && (data_out == $past(core_data))
               && (addr_out == $past(core_addr)));

   a_r5_inv_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (ahold && !ext_stb_n) |=> inv_valid && (inv_addr == ($past(ext_addr) & ~OFS_MASK)));

   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(ahold && !ext_stb_n) |=> !inv_valid);

   a_r8_stray_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!ahold && !ext_stb_n && err_cnt != CNT_TOP) |=> err_cnt == $past(err_cnt) + 1'b1);

   a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == CNT_TOP) |=> err_cnt == CNT_TOP);

endmodule

bind snp_ahold_port snp_ahold_port_chk #(
   .AW(AW), .DW(DW), .LINE_BITS(LINE_BITS), .CW(CW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ahold        (ahold),
   .ext_stb_n    (ext_stb_n),
   .ext_addr     (ext_addr),
   .core_addr    (core_addr),
   .core_data    (core_data),
   .core_data_en (core_data_en),
   .addr_out     (addr_out),
   .addr_oe      (addr_oe),
   .data_out     (data_out),
   .data_oe      (data_oe),
   .inv_valid    (inv_valid),
   .inv_addr     (inv_addr),
   .err_cnt      (err_cnt)
);

// File: tb/tb_snp_ahold_port.sv
`timescale 1ns/1ps
module tb_snp_ahold_port;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LB = 4;
   localparam int CW = 4;
   localparam logic [AW-1:0] MASK = 32'h0000_000F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ahold = 1'b0;
   logic          ext_stb_n = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] core_addr = '0;
   logic [DW-1:0] core_data = '0;
   logic          core_data_en = 1'b0;
   logic [AW-1:0] addr_out;
   logic          addr_oe;
   logic [DW-1:0] data_out;
   logic          data_oe;
   logic          inv_valid;
   logic [AW-1:0] inv_addr;
   logic [CW-1:0] err_cnt;

   int total = 0;
   int bad = 0;
   int strays = 0;
   bit done = 1'b0;
   logic [AW-1:0] expq[$];

   always #10 clk = ~clk;

   snp_ahold_port #(.AW(AW), .DW(DW), .LINE_BITS(LB), .CW(CW)) dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected invalidation addresses as pulses appear
   always @(negedge clk) begin
      if (rst_n && inv_valid) begin
         if (expq.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R7 actual=inv_valid=1 addr=%0h expected=no pulse", inv_addr);
         end else begin
            chk("R5/R6 inv_addr", 64'(inv_addr), 64'(expq.pop_front()));
         end
      end
   end

   // driver: one snoop strobe for one clock, expectation pushed to the queue
   task automatic snoop_one(input logic [AW-1:0] a);
      ext_stb_n = 1'b0;
      ext_addr  = a;
      expq.push_back(a & ~MASK);
      @(negedge clk);
   endtask

   task automatic stray(input logic [AW-1:0] a);
      ext_stb_n = 1'b0;
      ext_addr  = a;
      @(negedge clk);
      ext_stb_n = 1'b1;
      strays++;
      chk("R8 no pulse on stray", 64'(inv_valid), 64'd0);
      chk("R8/R9 err_cnt", 64'(err_cnt), 64'((strays > 15) ? 15 : strays));
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 addr_oe", 64'(addr_oe), 64'd1);
      chk("R1 data_oe", 64'(data_oe), 64'd0);
      chk("R1 inv_valid", 64'(inv_valid), 64'd0);
      chk("R1 err_cnt", 64'(err_cnt), 64'd0);

      core_addr = 32'h1234_5678; core_data = 32'hCAFE_0001; core_data_en = 1'b1;
      @(negedge clk);
      chk("R4 addr_out", 64'(addr_out), 64'h1234_5678);
      chk("R4 data_out", 64'(data_out), 64'hCAFE_0001);
      chk("R4 data_oe", 64'(data_oe), 64'd1);

      ahold = 1'b1;
      @(negedge clk);
      chk("R2 addr_oe low", 64'(addr_oe), 64'd0);
      chk("R4 data_oe during hold", 64'(data_oe), 64'd1);
      core_data_en = 1'b0; core_data = 32'h0BAD_F00D;
      @(negedge clk);
      chk("R4 data_oe drop in hold", 64'(data_oe), 64'd0);
      chk("R4 data_out in hold", 64'(data_out), 64'h0BAD_F00D);
      core_data_en = 1'b1;
      @(negedge clk);
      chk("R4 data_oe rise in hold", 64'(data_oe), 64'd1);
      chk("R2 addr_oe stays low", 64'(addr_oe), 64'd0);

      snoop_one(32'h0000_1237);
      ext_stb_n = 1'b1;
      @(negedge clk);
      chk("R7 idle after snoop", 64'(inv_valid), 64'd0);
      snoop_one(32'hFFFF_FFFF);
      ext_stb_n = 1'b1;
      @(negedge clk);
      snoop_one(32'h0000_0000);
      ext_stb_n = 1'b1;
      @(negedge clk);

      // back-to-back burst, R6
      snoop_one(32'hA000_0011);
      snoop_one(32'hB000_0022);
      snoop_one(32'hC000_003F);
      snoop_one(32'hD000_004E);
      ext_stb_n = 1'b1;
      @(negedge clk);
      chk("R6 burst drained", 64'(expq.size()), 64'd0);
      chk("R7 idle after burst", 64'(inv_valid), 64'd0);

      ahold = 1'b0;
      @(negedge clk);
      chk("R3 addr_oe back", 64'(addr_oe), 64'd1);

      for (int i = 0; i < 18; i++) stray(32'h5000_0000 + 32'(i));
      chk("R9 saturated", 64'(err_cnt), 64'd15);
      chk("R8 queue empty", 64'(expq.size()), 64'd0);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule